// File: doc/BRIEF.md
# Fetch-Stage Loop Buffer

This block sits in the instruction fetch stage. It keeps the instructions from the last few fetches that went to memory, and labels each one with the address it was fetched from. Every fetch request is compared against all stored addresses at once. If one matches, the instruction word is returned one cycle later and the memory port stays idle. If none matches, the block sends a single read to a simple instruction-memory port. It waits for the response, passes the word on to the fetch stage and stores it in the buffer. The new word goes into the slot that was written longest ago.

A short loop whose body fits in the buffer misses only on its first pass. Every later pass is served from the buffer alone. A flush input empties the buffer, for example after instruction memory has been rewritten. While a miss is outstanding, the block drops its ready signal and ignores any new requests.

Top module: `fetch_loop_buf`

## Requirements
- R1: While reset is held and just after it, `instr_valid_o` and `mem_req_o` are 0 and `fetch_ready_o` is 1.
- R2: An accepted request (`fetch_req_i` and `fetch_ready_o` both high on a clock edge) whose address is stored in the buffer raises `instr_valid_o` after that edge, with the stored word on `instr_o`. `mem_req_o` stays 0.
- R3: An accepted request that misses raises `mem_req_o` after that edge, with `mem_addr_o` equal to the request address. Both hold steady and `fetch_ready_o` stays 0 until the edge at which `mem_rsp_valid_i` is sampled high.
- R4: After the edge that samples `mem_rsp_valid_i` high during a miss, `instr_valid_o` is 1 for that cycle and `instr_o` equals `mem_rsp_data_i`. The word is stored under the miss address.
- R5: The buffer holds DEPTH words. Each fill replaces the slot written longest ago. After fills of addresses A0..A(DEPTH) in order, A0 misses and A1..A(DEPTH) hit.
- R6: A loop of up to DEPTH distinct addresses that is fetched repeatedly misses only on its first pass. A sequential loop longer than DEPTH misses on every fetch.
- R7: Once `flush_i` has been sampled high, every stored entry is invalid and the next fetch of any address misses.
- R8: If `flush_i` is high on the same edge as a memory response, the word is still delivered to the fetch stage (R4), but it is not kept. A later fetch of that address misses.
- R9: Requests presented while `fetch_ready_o` is 0 have no effect. No second memory read is issued, `mem_addr_o` keeps the pending address, and the word delivered is the one for the pending address.
- R10: The buffer never holds the same address in two valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all buffer entries |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | AW | Fetch address |
| fetch_ready_o | output | 1 | Request can be accepted this cycle |
| instr_valid_o | output | 1 | Instruction word valid |
| instr_o | output | IW | Instruction word |
| mem_req_o | output | 1 | Memory read outstanding |
| mem_addr_o | output | AW | Memory read address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | IW | Memory read data |

## Verification
A hit is due exactly one cycle after the edge that accepts the request. A miss shows up as `mem_req_o` one cycle after acceptance, and its word appears one cycle after the edge that samples the memory response. The bench drives its inputs on falling edges. For each fetch it checks the outputs at the very next falling edge, which tells hit from miss with no slack allowed. While playing the memory, it checks again at the falling edge that follows the response, and holds the response back by an amount that depends on the address. Whether a fetch should hit is worked out from the loop length, the buffer depth and the order of fills. Expected instruction words are a fixed arithmetic function of the address.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [0:0] {
    LB_IDLE = 1'b0,
    LB_WAIT = 1'b1
  } lb_state_e;
endpackage

// File: rtl/lbuf_rst_sync.sv
module lbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/lbuf_match.sv
module lbuf_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_sn,
  input  logic [DEPTH-1:0][AW-1:0]  tags_i,
  input  logic [DEPTH-1:0]          valid_i,
  input  logic [AW-1:0]             probe_i,
  output logic                      hit_o,
  output logic [IDXW-1:0]           hit_idx_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tags_i[g] == probe_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx_o = hit_idx_o | IDXW'(i);
    end
  end

  assign hit_o = |hit_vec;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(hit_vec)); // R10
endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int IW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_sn,
  input  logic                      flush_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [IW-1:0]             wr_data_i,
  input  logic [IDXW-1:0]           rd_idx_i,
  output logic [IW-1:0]             rd_data_o,
  output logic [DEPTH-1:0][AW-1:0]  tags_o,
  output logic [DEPTH-1:0]          valid_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  logic [DEPTH-1:0][IW-1:0] data_q;
  logic [DEPTH-1:0][AW-1:0] tag_q;
  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [IDXW-1:0]          wptr_q, wptr_d;
  logic                     wptr_en;

  // Write pointer: oldest slot, advanced per fill, rewound on flush.
  always_comb begin
    wptr_en = flush_i | wr_en_i;
    if (flush_i)             wptr_d = '0;
    else if (wptr_q == LAST) wptr_d = '0;
    else                     wptr_d = wptr_q + 1'b1;
  end

  always_comb begin
    vld_d = vld_q;
    if (flush_i)      vld_d = '0;
    else if (wr_en_i) vld_d[wptr_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wptr_q <= '0;
      vld_q  <= '0;
    end else begin
      if (wptr_en) wptr_q <= wptr_d;
      vld_q <= vld_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en_i && (wptr_q == IDXW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        data_q[g] <= wr_data_i;
        tag_q[g]  <= wr_addr_i;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign tags_o    = tag_q;
  assign valid_o   = vld_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sn)
    flush_i |=> (valid_o == '0)); // R7
  AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_sn)
    (flush_i && wr_en_i) |=> (valid_o == '0)); // R8
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl #(
  parameter int AW = 16,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          hit_i,
  input  logic [IW-1:0] hit_data_i,
  input  logic          mem_rsp_valid_i,
  input  logic [IW-1:0] mem_rsp_data_i,
  output logic          ready_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          fill_en_o,
  output logic [AW-1:0] fill_addr_o,
  output logic          instr_valid_o,
  output logic [IW-1:0] instr_o
);
  import lbuf_pkg::*;

  lb_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;
  logic          accept, waiting, rsp_take;
  logic          ovld_d;
  logic [IW-1:0] odata_d;
  logic          odata_en;

  assign waiting  = (state_q == LB_WAIT);
  assign ready_o  = !waiting;
  assign accept   = ready_o && fetch_req_i;
  assign rsp_take = waiting && mem_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    case (state_q)
      LB_IDLE: if (accept && !hit_i) begin
        state_d = LB_WAIT;
        addr_en = 1'b1;
      end
      LB_WAIT: if (mem_rsp_valid_i) state_d = LB_IDLE;
      default: state_d = LB_IDLE;
    endcase
  end

  always_comb begin
    ovld_d   = (accept && hit_i) || rsp_take;
    odata_en = ovld_d;
    odata_d  = rsp_take ? mem_rsp_data_i : hit_data_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q       <= LB_IDLE;
      instr_valid_o <= 1'b0;
    end else begin
      state_q       <= state_d;
      instr_valid_o <= ovld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en)  addr_q  <= fetch_addr_i;
    if (odata_en) instr_o <= odata_d;
  end

  assign mem_req_o   = waiting;
  assign mem_addr_o  = addr_q;
  assign fill_en_o   = rsp_take;
  assign fill_addr_o = addr_q;

  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3
  AST_RSP_DELIVERED: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req_o && mem_rsp_valid_i) |=> (instr_valid_o && !mem_req_o)); // R4
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ready_o && !mem_rsp_valid_i) |=> !instr_valid_o); // R9
endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int IW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic          fetch_ready_o,
  output logic          instr_valid_o,
  output logic [IW-1:0] instr_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [IW-1:0] mem_rsp_data_i
);
  logic                     rst_sn;
  logic                     hit;
  logic [IDXW-1:0]          hit_idx;
  logic [IW-1:0]            hit_data;
  logic [DEPTH-1:0][AW-1:0] tags;
  logic [DEPTH-1:0]         valids;
  logic                     fill_en;
  logic [AW-1:0]            fill_addr;

  lbuf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  lbuf_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .clk(clk), .rst_sn(rst_sn), .tags_i(tags), .valid_i(valids),
    .probe_i(fetch_addr_i), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  lbuf_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
    .clk(clk), .rst_sn(rst_sn), .flush_i(flush_i), .wr_en_i(fill_en),
    .wr_addr_i(fill_addr), .wr_data_i(mem_rsp_data_i), .rd_idx_i(hit_idx),
    .rd_data_o(hit_data), .tags_o(tags), .valid_o(valids)
  );

  lbuf_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .fetch_req_i(fetch_req_i),
    .fetch_addr_i(fetch_addr_i), .hit_i(hit), .hit_data_i(hit_data),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .ready_o(fetch_ready_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .fill_en_o(fill_en), .fill_addr_o(fill_addr),
    .instr_valid_o(instr_valid_o), .instr_o(instr_o)
  );

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_sn)
    (fetch_ready_o && fetch_req_i && hit) |=> (instr_valid_o && !mem_req_o)); // R2
  AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_sn)
    (fetch_ready_o && fetch_req_i && !hit) |=> (mem_req_o && !instr_valid_o)); // R3
endmodule

// File: tb/sim_fetch_loop_buf.sv
module sim_fetch_loop_buf;
  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int IW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          fetch_req_i = 1'b0;
  logic [AW-1:0] fetch_addr_i = '0;
  logic          fetch_ready_o, instr_valid_o, mem_req_o;
  logic [IW-1:0] instr_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [IW-1:0] mem_rsp_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fetch_loop_buf #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fetch_req_i(fetch_req_i),
    .fetch_addr_i(fetch_addr_i), .fetch_ready_o(fetch_ready_o),
    .instr_valid_o(instr_valid_o), .instr_o(instr_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i)
  );

  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    return {a, 8'h5C, a ^ 12'h3A5};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One fetch; serves memory if the design asks. exp_hit from the bench's own reasoning.
  task automatic do_fetch(input logic [AW-1:0] a, input bit exp_hit,
                          input bit flush_at_rsp, input string req);
    int lat;
    @(negedge clk);
    fetch_req_i  = 1'b1;
    fetch_addr_i = a;
    @(negedge clk);
    fetch_req_i = 1'b0;
    check(instr_valid_o == exp_hit, req, "hit/miss", IW'(instr_valid_o), IW'(exp_hit));
    if (instr_valid_o) begin
      check(instr_o == word_of(a), "R2", "hit word", instr_o, word_of(a));
      check(!mem_req_o, "R2", "no memory read on hit", IW'(mem_req_o), 0);
    end
    if (mem_req_o) begin
      check(mem_addr_o == a && !fetch_ready_o, "R3", "miss address",
            IW'(mem_addr_o), IW'(a));
      lat = 1 + int'(a % 3);
      for (int k = 0; k < lat; k++) begin
        if (k == 0) begin
          fetch_req_i  = 1'b1;      // stray request while busy
          fetch_addr_i = a ^ 12'h001;
        end
        @(negedge clk);
        fetch_req_i = 1'b0;
        check(mem_req_o && mem_addr_o == a && !instr_valid_o, "R9",
              "busy ignores request", IW'(mem_addr_o), IW'(a));
      end
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i  = word_of(a);
      flush_i         = flush_at_rsp;
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      flush_i         = 1'b0;
      check(instr_valid_o && instr_o == word_of(a) && !mem_req_o, "R4",
            "miss word delivered", instr_o, word_of(a));
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(!instr_valid_o && !mem_req_o && fetch_ready_o, "R1", "in reset",
          IW'({instr_valid_o, mem_req_o, fetch_ready_o}), IW'(3'b001));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!instr_valid_o && !mem_req_o && fetch_ready_o, "R1", "after reset",
          IW'({instr_valid_o, mem_req_o, fetch_ready_o}), IW'(3'b001));

    // R6 sweep: loop lengths 1..DEPTH+2, three passes each
    for (int len = 1; len <= DEPTH + 2; len++) begin
      pulse_flush();
      for (int pass = 0; pass < 3; pass++) begin
        for (int i = 0; i < len; i++) begin
          do_fetch(AW'(len * 64 + i), (pass > 0) && (len <= DEPTH), 1'b0, "R6");
        end
      end
    end

    // R5 oldest-first replacement
    pulse_flush();
    for (int i = 0; i <= DEPTH; i++) do_fetch(AW'(12'h100 + i), 1'b0, 1'b0, "R5");
    for (int i = 1; i <= DEPTH; i++) do_fetch(AW'(12'h100 + i), 1'b1, 1'b0, "R5");
    do_fetch(12'h100, 1'b0, 1'b0, "R5");
    do_fetch(12'h101, 1'b0, 1'b0, "R5");

    // R7 flush invalidates
    do_fetch(12'h103, 1'b1, 1'b0, "R7");
    pulse_flush();
    do_fetch(12'h103, 1'b0, 1'b0, "R7");
    do_fetch(12'h100, 1'b0, 1'b0, "R7");

    // R8 flush on the fill edge
    do_fetch(12'h200, 1'b0, 1'b1, "R8");
    do_fetch(12'h200, 1'b0, 1'b0, "R8");
    do_fetch(12'h200, 1'b1, 1'b0, "R8");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule